// File: doc/BRIEF.md
# Light Pen Position Capture

This block sits beside a CRT controller and records where the beam was at a chosen moment. It holds one strobe flip-flop. The strobe can be set by the external pen input or by software touching a set port on the I/O bus. When the strobe goes from low to high, the block freezes the controller's live display address and row counter into holding registers, and software reads them afterwards.

A set through the port lets a program sample the beam position whenever it chooses. A second port clears the strobe, and the strobe must be cleared before another position can be taken. The position has one-character resolution horizontally. It has two-scanline resolution in graphics modes, because the display address only advances once per character and once per pair of lines.

The captured values are read with an index/data pair. A write to the index port selects a register, and a read of the data port returns that register.

Top module: `pen_pos_latch`

## Requirements
- R1: After reset the strobe is low, the captured address and row are zero, and the index register is zero.
- R2: Any read or write at the clear port (0x3DB) makes the strobe low after the next rising clock edge.
- R3: Any read or write at the set port (0x3DC) while the strobe is low makes it high after that edge, and it captures `ma_i` and `ra_i` as sampled at that edge.
- R4: The pen input passes through two synchronising flip-flops. Pen high before rising edge k sets the strobe at edge k+2, and the capture takes `ma_i` and `ra_i` sampled at edge k+2.
- R5: A capture happens only on a low-to-high change of the strobe. While the strobe is high, further pen pulses and set-port accesses leave the captured address and row unchanged.
- R6: When a clear-port access and a set request (pen or port) occur at the same edge, the clear wins and the strobe ends low.
- R7: A write to the index port (0x3D4) stores `io_wdata_i`. A read of the data port (0x3D5) returns one of the following, selected by the stored index:
  - index 0x10: address bits 13:8 in data bits 5:0, with the upper bits zero;
  - index 0x11: address bits 7:0;
  - index 0x12: the row in bits 4:0;
  - any other index: 0x00.
- R8: `io_rdata_o` is 0x00 whenever there is no data-port read. A write to the data port changes nothing that can be read back.
- R9: After a clear, the next set captures the new live position, not the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 10 | I/O port address |
| io_rd_i | input | 1 | I/O read strobe, one cycle per access |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational |
| pen_i | input | 1 | Asynchronous pen trigger, active high |
| ma_i | input | 14 | Live display address from the controller |
| ra_i | input | 5 | Live row counter from the controller |
| strobe_o | output | 1 | Strobe flip-flop state |
| pos_o | output | 14 | Captured display address |
| row_o | output | 5 | Captured row counter |

## Verification
The assertions assume that the pen input is low from reset for at least three cycles. This keeps the pen-origin check from relying on samples taken before reset. The assertions also assume that the read and write strobes only ever refer to the single address on the bus in that cycle. The stimulus drives every input at the falling clock edge, holds the pen low during and right after reset, and never raises a read and a write in the same cycle. The clear-versus-set conflict is produced only by holding the pen high across a clear-port access.

// File: rtl/pen_pos_pkg.sv
package pen_pos_pkg;

    localparam logic [7:0] IDX_POS_HI = 8'h10;
    localparam logic [7:0] IDX_POS_LO = 8'h11;
    localparam logic [7:0] IDX_ROW    = 8'h12;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_HI,
        SEL_LO,
        SEL_ROW
    } pen_sel_e;

    function automatic pen_sel_e decode_index(input logic [7:0] idx);
        case (idx)
            IDX_POS_HI: return SEL_HI;
            IDX_POS_LO: return SEL_LO;
            IDX_ROW:    return SEL_ROW;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pen_sync.sv
module pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pen_bus_decode.sv
module pen_bus_decode #(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] SET_PORT  = 10'h3DC,
    parameter logic [ADDR_W-1:0] CLR_PORT  = 10'h3DB,
    parameter logic [ADDR_W-1:0] IDX_PORT  = 10'h3D4,
    parameter logic [ADDR_W-1:0] DATA_PORT = 10'h3D5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic              set_acc_o,
    output logic              clr_acc_o,
    output logic              idx_we_o,
    output logic              data_re_o
);
    logic any_acc;

    always_comb begin
        any_acc   = rd_i | wr_i;
        set_acc_o = any_acc && (addr_i == SET_PORT);
        clr_acc_o = any_acc && (addr_i == CLR_PORT);
        idx_we_o  = wr_i && (addr_i == IDX_PORT);
        data_re_o = rd_i && (addr_i == DATA_PORT);
    end
endmodule

// File: rtl/pen_pos_latch.sv
module pen_pos_latch
    import pen_pos_pkg::*;
#(
    parameter int              ADDR_W      = 10,
    parameter int              MA_W        = 14,
    parameter int              RA_W        = 5,
    parameter int              SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] SET_PORT    = 10'h3DC,
    parameter logic [ADDR_W-1:0] CLR_PORT    = 10'h3DB,
    parameter logic [ADDR_W-1:0] IDX_PORT    = 10'h3D4,
    parameter logic [ADDR_W-1:0] DATA_PORT   = 10'h3D5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    input  logic [7:0]        io_wdata_i,
    output logic [7:0]        io_rdata_o,
    input  logic              pen_i,
    input  logic [MA_W-1:0]   ma_i,
    input  logic [RA_W-1:0]   ra_i,
    output logic              strobe_o,
    output logic [MA_W-1:0]   pos_o,
    output logic [RA_W-1:0]   row_o
);
    localparam int POS_EXT_W = 16;
    localparam int ROW_EXT_W = 8;

    typedef struct packed {
        logic            strobe;
        logic [MA_W-1:0] pos;
        logic [RA_W-1:0] row;
        logic [7:0]      idx;
    } state_t;

    state_t st_d, st_q;

    logic pen_s;
    logic set_acc, clr_acc, idx_we, data_re;
    logic set_any;
    logic [POS_EXT_W-1:0] pos_ext;
    logic [ROW_EXT_W-1:0] row_ext;

    pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pen_i),
        .sync_o  (pen_s)
    );

    pen_bus_decode #(
        .ADDR_W    (ADDR_W),
        .SET_PORT  (SET_PORT),
        .CLR_PORT  (CLR_PORT),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_dec (
        .addr_i    (io_addr_i),
        .rd_i      (io_rd_i),
        .wr_i      (io_wr_i),
        .set_acc_o (set_acc),
        .clr_acc_o (clr_acc),
        .idx_we_o  (idx_we),
        .data_re_o (data_re)
    );

    always_comb begin
        st_d    = st_q;
        set_any = set_acc | pen_s;
        if (idx_we) st_d.idx = io_wdata_i;
        if (clr_acc) begin
            st_d.strobe = 1'b0;
        end else if (set_any) begin
            st_d.strobe = 1'b1;
            if (!st_q.strobe) begin
                st_d.pos = ma_i;
                st_d.row = ra_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        pos_ext    = POS_EXT_W'(st_q.pos);
        row_ext    = ROW_EXT_W'(st_q.row);
        io_rdata_o = 8'h00;
        if (data_re) begin
            case (decode_index(st_q.idx))
                SEL_HI:  io_rdata_o = pos_ext[15:8];
                SEL_LO:  io_rdata_o = pos_ext[7:0];
                SEL_ROW: io_rdata_o = row_ext;
                default: io_rdata_o = 8'h00;
            endcase
        end
    end

    assign strobe_o = st_q.strobe;
    assign pos_o    = st_q.pos;
    assign row_o    = st_q.row;
endmodule

// File: rtl/pen_pos_latch_chk.sv
module pen_pos_latch_chk #(
    parameter int              ADDR_W   = 10,
    parameter int              MA_W     = 14,
    parameter int              RA_W     = 5,
    parameter logic [ADDR_W-1:0] SET_PORT = 10'h3DC,
    parameter logic [ADDR_W-1:0] CLR_PORT = 10'h3DB
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] io_addr_i,
    input logic              io_rd_i,
    input logic              io_wr_i,
    input logic              pen_i,
    input logic [MA_W-1:0]   ma_i,
    input logic [RA_W-1:0]   ra_i,
    input logic              strobe_o,
    input logic [MA_W-1:0]   pos_o,
    input logic [RA_W-1:0]   row_o
);
    logic set_hit, clr_hit;
    assign set_hit = (io_rd_i | io_wr_i) && (io_addr_i == SET_PORT);
    assign clr_hit = (io_rd_i | io_wr_i) && (io_addr_i == CLR_PORT);

    p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_hit |=> !strobe_o);

    p_set_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_hit && !clr_hit && !strobe_o) |=>
            (strobe_o && pos_o == $past(ma_i) && row_o == $past(ra_i)));

    p_pen_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(strobe_o) && !$past(set_hit)) |-> $past(pen_i, 3));

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_o && !clr_hit) |=> (strobe_o && $stable(pos_o) && $stable(row_o)));

    p_only_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pos_o) |-> $rose(strobe_o));

    p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_hit && $past(pen_i, 2)) |=> !strobe_o);
endmodule

bind pen_pos_latch pen_pos_latch_chk #(
    .ADDR_W   (ADDR_W),
    .MA_W     (MA_W),
    .RA_W     (RA_W),
    .SET_PORT (SET_PORT),
    .CLR_PORT (CLR_PORT)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .io_addr_i (io_addr_i),
    .io_rd_i   (io_rd_i),
    .io_wr_i   (io_wr_i),
    .pen_i     (pen_i),
    .ma_i      (ma_i),
    .ra_i      (ra_i),
    .strobe_o  (strobe_o),
    .pos_o     (pos_o),
    .row_o     (row_o)
);

// File: tb/pen_pos_latch_tb_top.sv
`timescale 1ns/1ps
module pen_pos_latch_tb_top;
    localparam logic [9:0] P_SET  = 10'h3DC;
    localparam logic [9:0] P_CLR  = 10'h3DB;
    localparam logic [9:0] P_IDX  = 10'h3D4;
    localparam logic [9:0] P_DATA = 10'h3D5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        pen = 1'b0;
    logic [13:0] ma = '0;
    logic [4:0]  ra = '0;
    logic        strobe;
    logic [13:0] pos;
    logic [4:0]  row;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pen_pos_latch dut_i (
        .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_rd_i(rd), .io_wr_i(wr),
        .io_wdata_i(wdata), .io_rdata_o(rdata), .pen_i(pen), .ma_i(ma), .ra_i(ra),
        .strobe_o(strobe), .pos_o(pos), .row_o(row)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access across one rising edge; ends at the following falling edge
    task automatic access(input logic [9:0] a, input bit is_rd, input logic [7:0] d);
        @(negedge clk);
        addr = a; rd = is_rd; wr = !is_rd; wdata = d;
        @(negedge clk);
        rd = 0; wr = 0;
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
        access(P_IDX, 0, idx);
        addr = P_DATA; rd = 1;
        #1 v = rdata;
        @(negedge clk);
        rd = 0;
    endtask

    task automatic set_with_pos(input logic [13:0] a, input logic [4:0] r, input bit use_rd);
        @(negedge clk);
        addr = P_SET; rd = use_rd; wr = !use_rd; ma = a; ra = r;
        @(negedge clk);
        rd = 0; wr = 0; ma = ~a; ra = ~r;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [13:0] a;
        logic [4:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 strobe", strobe, 0);
        check("R1 pos", pos, 0);
        check("R1 row", row, 0);
        addr = P_DATA; rd = 1; #1 check("R1 idx zero reads 0", rdata, 0);
        @(negedge clk); rd = 0;

        // R3/R9/R2/R7 sweep with corners
        for (int i = 0; i < 260; i++) begin
            a = (i == 0) ? 14'h0000 : (i == 1) ? 14'h3FFF : 14'((i * 1237 + 91) & 16'h3FFF);
            r = 5'(i * 7);
            access(P_CLR, i[0], 8'h00);
            check("R2 clear", strobe, 0);
            set_with_pos(a, r, i[1]);
            check("R3 strobe set", strobe, 1);
            check("R9 pos new", pos, a);
            check("R3 row", row, r);
            read_reg(8'h10, v); check("R7 hi byte", v, {2'b00, a[13:8]});
            read_reg(8'h11, v); check("R7 lo byte", v, a[7:0]);
            read_reg(8'h12, v); check("R7 row byte", v, {3'b000, r});
        end

        // R5: further sets ignored while high
        access(P_CLR, 0, 0);
        set_with_pos(14'h1A2B, 5'd9, 0);
        set_with_pos(14'h0555, 5'd3, 1);
        check("R5 port set ignored pos", pos, 14'h1A2B);
        check("R5 port set ignored row", row, 9);
        @(negedge clk); pen = 1; ma = 14'h2222;
        repeat (5) @(negedge clk);
        pen = 0;
        repeat (3) @(negedge clk);
        check("R5 pen ignored pos", pos, 14'h1A2B);
        check("R5 strobe stays", strobe, 1);

        // R4 pen through two-stage sync
        access(P_CLR, 0, 0);
        repeat (3) @(negedge clk);
        pen = 1; ma = 14'h0101; ra = 5'd1;
        @(negedge clk); check("R4 edge1 low", strobe, 0); ma = 14'h0202; ra = 5'd2;
        @(negedge clk); check("R4 edge2 low", strobe, 0); ma = 14'h0303; ra = 5'd3;
        @(negedge clk); check("R4 edge3 high", strobe, 1);
        check("R4 pos", pos, 14'h0303);
        check("R4 row", row, 3);

        // R6 clear wins with pen held high
        ma = 14'h3A5C; ra = 5'd17;
        @(negedge clk);
        addr = P_CLR; wr = 1;
        @(negedge clk);
        wr = 0;
        check("R6 clear wins", strobe, 0);
        @(negedge clk);
        check("R6 pen resets after", strobe, 1);
        check("R6 recapture", pos, 14'h3A5C);
        pen = 0;
        repeat (3) @(negedge clk);

        // R8 data-port write has no effect, idle read data zero
        access(P_DATA, 0, 8'hFF);
        check("R8 pos after data write", pos, 14'h3A5C);
        read_reg(8'h11, v); check("R8 lo after data write", v, 8'h5C);
        read_reg(8'h05, v); check("R7 unknown index", v, 0);
        access(P_IDX, 0, 8'h11);
        #1 check("R8 rdata idle", rdata, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule